// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous static memory. Every control, address and write-enable input is sampled on the rising clock edge. Read and write cycles can follow each other on consecutive clocks with no idle cycle between them. The block does this by taking write data a fixed number of edges after the address that goes with it. A mode input picks one of two timings:

- **Flow-through:** write data lags by one edge, and read data comes straight from the array.
- **Pipelined:** write data lags by two edges, and read data passes through an output register, so a 4-beat burst runs 3-1-1-1 instead of 2-1-1-1.

Three chip selects gate each new access. Writes are masked per 9-bit byte lane. A 2-bit burst counter walks the low address bits in linear or interleaved order. An asynchronous output enable can turn the data driver off at any moment.

In pipelined mode a read can reach an address whose write data has not arrived yet. When that happens, the core merges the incoming data byte by byte into the value it returns, so a read always reflects the newest write. The output bus is a data vector plus a drive-enable flag, which a pad ring combines into a tri-state pin. The mode and burst-order inputs are static and are changed only while reset is held.

Top module: `lw_sram`

## Requirements
- R1: In flow-through mode (`pipe_mode`=0), a selected read sampled at edge t drives `dq_oe`=1 and the word on `dq_o` from just after edge t until edge t+1.
- R2: In pipelined mode (`pipe_mode`=1), a selected read sampled at edge t drives its word from just after edge t+1 until edge t+2.
- R3: The data of a write sampled at edge t is taken from `wdata` at edge t+1 in flow-through mode and at edge t+2 in pipelined mode; the value on `wdata` at any other edge has no effect on that write.
- R4: Reads and writes may be issued in any order on consecutive edges. A read returns the most recent earlier write to the same word, including a write whose data arrives at the same edge the read result is formed, with the merge done per byte lane.
- R5: Byte lane i covers data bits [9i+8:9i]. A write stores lane i only when `bw_n[i]` is 0 in the cycle that carries the address, and leaves lanes with `bw_n[i]`=1 unchanged.
- R6: A new access (`adv`=0) is selected only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. A deselected access stores nothing and drives nothing. Burst continuation cycles inherit the selection of their load.
- R7: `oe_n`=1 forces `dq_oe` to 0 at once, without waiting for a clock edge. Returning `oe_n` to 0 restores the drive of a read still in its output window.
- R8: With `adv`=1 the previous access continues as the next burst beat, keeping its read/write type. With `intlv`=0, beat k addresses the word whose two low address bits are (base + k) mod 4 and whose upper bits equal the base.
- R9: With `intlv`=1, beat k addresses the word whose two low address bits are base XOR k, with the upper bits unchanged.
- R10: After reset, `dq_oe` is 0 and no read or write is pending. Array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control pipeline |
| pipe_mode | input | 1 | 1 = pipelined timing, 0 = flow-through timing (static) |
| intlv | input | 1 | Burst order: 0 = linear, 1 = interleaved (static) |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = continue burst, 0 = load new address and command |
| we_n | input | 1 | 0 = write, 1 = read (sampled on loads) |
| bw_n | input | NBYTES | Per-lane write mask, active low |
| addr | input | ADDR_W | Word address (sampled on loads) |
| wdata | input | NBYTES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_o | output | NBYTES*BYTE_W | Read data, zero when not driving |
| dq_oe | output | 1 | Output driver enable |

## Verification
The embedded properties check a subset of behaviour on every cycle:

- read-drive timing in each mode, measured from the sampled command;
- silence after a deselected load;
- the burst page staying fixed, and linear beats stepping by one;
- the forwarded lane in pipelined mode matching the data on the write bus.

The bench scenarios cover what only stored contents can reveal:

- the per-lane merge;
- writes that were masked or deselected;
- which edge takes the late data;
- the full interleaved beat order;
- the asynchronous effect of `oe_n`, which has no clock edge to reason from.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;

   localparam int BEAT_W = 2;

   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } burst_ord_e;

   function automatic logic [BEAT_W-1:0] beat_offset(
      input logic [BEAT_W-1:0] base,
      input logic [BEAT_W-1:0] beat,
      input burst_ord_e        ord
   );
      if (ord == ORD_XOR) return base ^ beat;
      return base + beat;
   endfunction

endpackage

// File: rtl/lw_sram_cmd.sv
`timescale 1ns/1ps
module lw_sram_cmd
   import lw_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NBYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_a_n,
   input  logic              ce_b,
   input  logic              ce_c_n,
   input  logic              adv,
   input  logic              we_n,
   input  logic [NBYTES-1:0] bw_n,
   input  logic [ADDR_W-1:0] addr,
   input  burst_ord_e        ord,
   output logic              s1_vld,
   output logic              s1_wr,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [NBYTES-1:0] s1_be,
   output logic              s2_vld,
   output logic              s2_wr,
   output logic [ADDR_W-1:0] s2_addr,
   output logic [NBYTES-1:0] s2_be
);

   localparam int PAGE_W = ADDR_W - BEAT_W;

   generate
      if (ADDR_W < BEAT_W + 1) begin : g_bad_aw
         $error("lw_sram_cmd: ADDR_W must exceed the burst beat width");
      end
      if (NBYTES < 1) begin : g_bad_nb
         $error("lw_sram_cmd: NBYTES must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] base_q;
   logic [BEAT_W-1:0] beat_q;
   logic              sel_q;
   logic              wr_q;

   logic              sel_now;
   logic [ADDR_W-1:0] base_nxt;
   logic [BEAT_W-1:0] beat_nxt;
   logic              sel_nxt;
   logic              wr_nxt;
   logic [ADDR_W-1:0] eff_addr;

   assign sel_now = !ce_a_n && ce_b && !ce_c_n;

   always_comb begin
      if (!adv) begin
         base_nxt = addr;
         beat_nxt = '0;
         sel_nxt  = sel_now;
         wr_nxt   = !we_n;
      end else begin
         base_nxt = base_q;
         beat_nxt = beat_q + 1'b1;
         sel_nxt  = sel_q;
         wr_nxt   = wr_q;
      end
      eff_addr = {base_nxt[ADDR_W-1:BEAT_W],
                  beat_offset(base_nxt[BEAT_W-1:0], beat_nxt, ord)};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         beat_q  <= '0;
         sel_q   <= 1'b0;
         wr_q    <= 1'b0;
         s1_vld  <= 1'b0;
         s1_wr   <= 1'b0;
         s1_addr <= '0;
         s1_be   <= '0;
         s2_vld  <= 1'b0;
         s2_wr   <= 1'b0;
         s2_addr <= '0;
         s2_be   <= '0;
      end else begin
         base_q  <= base_nxt;
         beat_q  <= beat_nxt;
         sel_q   <= sel_nxt;
         wr_q    <= wr_nxt;
         s1_vld  <= sel_nxt;
         s1_wr   <= wr_nxt;
         s1_addr <= eff_addr;
         s1_be   <= ~bw_n;
         s2_vld  <= s1_vld;
         s2_wr   <= s1_wr;
         s2_addr <= s1_addr;
         s2_be   <= s1_be;
      end
   end

   // R9: a continued beat never leaves the page of its load
   a_r9_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> s1_addr[ADDR_W-1:BEAT_W] == $past(s1_addr[ADDR_W-1:BEAT_W]));

   // R8: in linear order each continued beat steps the low bits by one
   a_r8_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      adv && ord == ORD_LINEAR && $stable(ord)
      |=> s1_addr[BEAT_W-1:0] == $past(s1_addr[BEAT_W-1:0]) + 2'd1);

   logic [PAGE_W-1:0] unused_page;
   assign unused_page = base_q[ADDR_W-1:BEAT_W];

endmodule

// File: rtl/lw_sram_array.sv
`timescale 1ns/1ps
module lw_sram_array #(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 2
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [NBYTES-1:0]        wbe,
   input  logic [NBYTES*BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [NBYTES*BYTE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (DEPTH * NBYTES > 4096) begin : g_bad_size
         $error("lw_sram_array: array too large for a flop implementation");
      end
      for (genvar ln = 0; ln < NBYTES; ln++) begin : g_lane
         logic [BYTE_W-1:0] lane_mem [DEPTH];

         always_ff @(posedge clk) begin
            if (we && wbe[ln]) lane_mem[waddr] <= wdata[ln*BYTE_W +: BYTE_W];
         end

         assign rdata[ln*BYTE_W +: BYTE_W] = lane_mem[raddr];
      end
   endgenerate

endmodule

// File: rtl/lw_sram_rdpath.sv
`timescale 1ns/1ps
module lw_sram_rdpath #(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pipe,
   input  logic                     s1_vld,
   input  logic                     s1_wr,
   input  logic [ADDR_W-1:0]        s1_addr,
   input  logic                     s2_vld,
   input  logic                     s2_wr,
   input  logic [ADDR_W-1:0]        s2_addr,
   input  logic [NBYTES-1:0]        s2_be,
   input  logic [NBYTES*BYTE_W-1:0] wdata,
   input  logic [NBYTES*BYTE_W-1:0] mem_rdata,
   output logic [NBYTES*BYTE_W-1:0] rd_data,
   output logic                     rd_drive
);

   localparam int DATA_W = NBYTES * BYTE_W;

   logic              fwd_hit;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] rd_q;
   logic              rd_vld_q;

   assign fwd_hit = s2_vld && s2_wr && (s2_addr == s1_addr);

   generate
      for (genvar ln = 0; ln < NBYTES; ln++) begin : g_fwd
         assign merged[ln*BYTE_W +: BYTE_W] = (fwd_hit && s2_be[ln])
                                            ? wdata[ln*BYTE_W +: BYTE_W]
                                            : mem_rdata[ln*BYTE_W +: BYTE_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q     <= '0;
         rd_vld_q <= 1'b0;
      end else begin
         rd_vld_q <= s1_vld && !s1_wr;
         if (s1_vld && !s1_wr) rd_q <= merged;
      end
   end

   always_comb begin
      if (pipe) begin
         rd_data  = rd_q;
         rd_drive = rd_vld_q;
      end else begin
         rd_data  = mem_rdata;
         rd_drive = s1_vld && !s1_wr;
      end
   end

   // R4: a read meeting a pending write captures the arriving lane data
   a_r4_forward_lane: assert property (@(posedge clk) disable iff (!rst_n)
      pipe && s1_vld && !s1_wr && s2_vld && s2_wr && s2_addr == s1_addr && s2_be[0]
      |=> rd_q[BYTE_W-1:0] == $past(wdata[BYTE_W-1:0]));

endmodule

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram
   import lw_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BYTE_W = 9,
   parameter int NBYTES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pipe_mode,
   input  logic                     intlv,
   input  logic                     ce_a_n,
   input  logic                     ce_b,
   input  logic                     ce_c_n,
   input  logic                     adv,
   input  logic                     we_n,
   input  logic [NBYTES-1:0]        bw_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [NBYTES*BYTE_W-1:0] wdata,
   input  logic                     oe_n,
   output logic [NBYTES*BYTE_W-1:0] dq_o,
   output logic                     dq_oe
);

   localparam int DATA_W = NBYTES * BYTE_W;

   generate
      if (BYTE_W < 1) begin : g_bad_bw
         $error("lw_sram: BYTE_W must be at least 1");
      end
   endgenerate

   logic              s1_vld, s1_wr, s2_vld, s2_wr;
   logic [ADDR_W-1:0] s1_addr, s2_addr;
   logic [NBYTES-1:0] s1_be, s2_be;
   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [NBYTES-1:0] wr_be;
   logic [DATA_W-1:0] mem_rdata;
   logic [DATA_W-1:0] rd_data;
   logic              rd_drive;

   lw_sram_cmd #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_cmd (
      .clk(clk), .rst_n(rst_n),
      .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
      .adv(adv), .we_n(we_n), .bw_n(bw_n), .addr(addr),
      .ord(burst_ord_e'(intlv)),
      .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr), .s1_be(s1_be),
      .s2_vld(s2_vld), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_be(s2_be)
   );

   always_comb begin
      if (pipe_mode) begin
         wr_en   = s2_vld && s2_wr;
         wr_addr = s2_addr;
         wr_be   = s2_be;
      end else begin
         wr_en   = s1_vld && s1_wr;
         wr_addr = s1_addr;
         wr_be   = s1_be;
      end
   end

   lw_sram_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_array (
      .clk(clk), .we(wr_en), .waddr(wr_addr), .wbe(wr_be), .wdata(wdata),
      .raddr(s1_addr), .rdata(mem_rdata)
   );

   lw_sram_rdpath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_rd (
      .clk(clk), .rst_n(rst_n), .pipe(pipe_mode),
      .s1_vld(s1_vld), .s1_wr(s1_wr), .s1_addr(s1_addr),
      .s2_vld(s2_vld), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_be(s2_be),
      .wdata(wdata), .mem_rdata(mem_rdata),
      .rd_data(rd_data), .rd_drive(rd_drive)
   );

   assign dq_oe = rd_drive && !oe_n;
   assign dq_o  = rd_drive ? rd_data : '0;

   logic rd_load;
   assign rd_load = !adv && !ce_a_n && ce_b && !ce_c_n && we_n;

   // R1: flow-through read drives in the cycle after its sampling edge
   a_r1_flow_latency: assert property (@(posedge clk) disable iff (!rst_n)
      !pipe_mode && rd_load |=> (dq_oe || oe_n || pipe_mode));

   // R2: pipelined read drives one edge later than flow-through
   a_r2_pipe_latency: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_mode && rd_load |-> ##2 (dq_oe || oe_n || !pipe_mode));

   // R6: a deselected load leaves the bus undriven in flow-through mode
   a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !pipe_mode && !adv && !(!ce_a_n && ce_b && !ce_c_n) |=> (!dq_oe || pipe_mode));

endmodule

// File: tb/sim_lw_sram.sv
`timescale 1ns/1ps
module sim_lw_sram;

   localparam int AW = 8;
   localparam int BW = 9;
   localparam int NB = 2;
   localparam int DW = NB * BW;
   localparam int SMAX = 48;
   localparam int NVEC = 15;

   // {write, addr[7:0], bw_n[1:0], data[17:0]}
   localparam logic [28:0] VEC [NVEC] = '{
      {1'b1, 8'h10, 2'b00, 18'h12345},
      {1'b1, 8'h11, 2'b00, 18'h2ABCD},
      {1'b0, 8'h10, 2'b00, 18'h00000},
      {1'b1, 8'h10, 2'b10, 18'h3FFFF},
      {1'b0, 8'h10, 2'b00, 18'h00000},
      {1'b0, 8'h11, 2'b00, 18'h00000},
      {1'b1, 8'h11, 2'b01, 18'h00000},
      {1'b0, 8'h11, 2'b00, 18'h00000},
      {1'b1, 8'h12, 2'b00, 18'h0F0F0},
      {1'b1, 8'h13, 2'b00, 18'h30303},
      {1'b0, 8'h12, 2'b00, 18'h00000},
      {1'b0, 8'h13, 2'b00, 18'h00000},
      {1'b0, 8'h10, 2'b00, 18'h00000},
      {1'b1, 8'h12, 2'b11, 18'h3FFFF},
      {1'b0, 8'h12, 2'b00, 18'h00000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pipe_mode = 1'b0;
   logic intlv = 1'b0;
   logic ce_a_n = 1'b1;
   logic ce_b = 1'b0;
   logic ce_c_n = 1'b1;
   logic adv = 1'b0;
   logic we_n = 1'b1;
   logic oe_n = 1'b0;
   logic [NB-1:0] bw_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] dq_o;
   logic dq_oe;

   always #2.5 clk = ~clk;

   lw_sram #(.ADDR_W(AW), .BYTE_W(BW), .NBYTES(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .intlv(intlv),
      .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .adv(adv), .we_n(we_n),
      .bw_n(bw_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
      .dq_o(dq_o), .dq_oe(dq_oe)
   );

   int n_chk = 0;
   int n_bad = 0;

   logic [DW-1:0] ref_mem [1 << AW];
   logic          s_we   [SMAX];
   logic          s_dreq [SMAX];
   logic          s_adv  [SMAX];
   logic [AW-1:0] s_addr [SMAX];
   logic [NB-1:0] s_bw   [SMAX];
   logic [DW-1:0] s_data [SMAX];
   logic [1:0]    s_cs   [SMAX];
   int            s_chk  [SMAX];
   logic [DW-1:0] s_exp  [SMAX];
   string         s_tag  [SMAX];
   int            sn = 0;

   logic [AW-1:0] m_base;
   logic [1:0]    m_beat;
   logic          m_sel;
   logic          m_wr;

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp,
                        input logic gdrv, input logic edrv);
      n_chk++;
      if (gdrv !== edrv || (edrv && got !== exp)) begin
         n_bad++;
         $display("FAIL %s: dq_o=%h dq_oe=%b expected dq_o=%h dq_oe=%b",
                  tag, got, gdrv, exp, edrv);
      end
   endtask

   // reference model: burst addressing (R8, R9), select (R6), lanes (R5)
   task automatic add(input logic wr, input logic cont, input logic [AW-1:0] a,
                      input logic [NB-1:0] bwn, input logic [DW-1:0] d,
                      input logic [1:0] cs, input string tag);
      logic [AW-1:0] ea;
      if (!cont) begin
         m_base = a; m_beat = 2'd0; m_sel = (cs == 2'd0); m_wr = wr;
      end else begin
         m_beat = m_beat + 2'd1;
      end
      ea = {m_base[AW-1:2], intlv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat)};
      s_we[sn] = wr; s_adv[sn] = cont; s_addr[sn] = a; s_bw[sn] = bwn;
      s_data[sn] = d; s_cs[sn] = cs; s_tag[sn] = tag; s_dreq[sn] = m_wr;
      s_exp[sn] = '0;
      if (m_wr) begin
         s_chk[sn] = 0;
         if (m_sel)
            for (int b = 0; b < NB; b++)
               if (!bwn[b]) ref_mem[ea][b*BW +: BW] = d[b*BW +: BW];
      end else if (m_sel) begin
         s_chk[sn] = 1;
         s_exp[sn] = ref_mem[ea];
      end else begin
         s_chk[sn] = 2;
      end
      sn++;
   endtask

   task automatic idle_inputs();
      adv = 1'b0; we_n = 1'b1; ce_a_n = 1'b1; ce_b = 1'b0; ce_c_n = 1'b1;
      bw_n = '1; addr = '0;
   endtask

   // drives the stream; data lag and read latency are both lat edges (R1, R2, R3)
   task automatic run(input int lat);
      for (int k = 0; k < sn + lat + 1; k++) begin
         @(negedge clk);
         if (k - lat >= 0 && k - lat < sn && s_chk[k-lat] != 0)
            check(s_tag[k-lat], dq_o, s_exp[k-lat], dq_oe, s_chk[k-lat] == 1);
         if (k - lat >= 0 && k - lat < sn && s_dreq[k-lat]) wdata = s_data[k-lat];
         else wdata = '0;
         if (k < sn) begin
            adv = s_adv[k]; we_n = !s_we[k]; addr = s_addr[k]; bw_n = s_bw[k];
            ce_a_n = (s_cs[k] == 2'd1); ce_b = (s_cs[k] != 2'd2); ce_c_n = (s_cs[k] == 2'd3);
         end else begin
            idle_inputs();
         end
      end
      sn = 0;
   endtask

   task automatic do_reset(input logic pm);
      @(negedge clk);
      rst_n = 1'b0; idle_inputs(); wdata = '0;
      pipe_mode = pm;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 reset drive", dq_o, '0, dq_oe, 1'b0);
   endtask

   task automatic table_pass(input logic [DW-1:0] mask, input string tag);
      for (int i = 0; i < NVEC; i++)
         add(VEC[i][28], 1'b0, VEC[i][27:20], VEC[i][19:18], VEC[i][17:0] ^ mask, 2'd0, tag);
   endtask

   task automatic burst_pass(input int lat, input logic [DW-1:0] seed, input string tag8,
                             input string tag9);
      // fill a page of four words with single writes
      for (int i = 0; i < 4; i++)
         add(1'b1, 1'b0, 8'h20 + AW'(i), 2'b00, seed + DW'(i), 2'd0, "fill");
      intlv = 1'b0;
      add(1'b0, 1'b0, 8'h22, 2'b00, '0, 2'd0, tag8);
      for (int i = 0; i < 3; i++) add(1'b0, 1'b1, 8'h00, 2'b00, '0, 2'd0, tag8);
      run(lat);
      intlv = 1'b1;
      add(1'b0, 1'b0, 8'h21, 2'b00, '0, 2'd0, tag9);
      for (int i = 0; i < 3; i++) add(1'b0, 1'b1, 8'h00, 2'b00, '0, 2'd0, tag9);
      run(lat);
      intlv = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;

      // ---------------- flow-through ----------------
      do_reset(1'b0);
      table_pass('0, "R1 R4 R5 flow vector");
      run(1);

      // R3: late data taken one edge after the address
      add(1'b1, 1'b0, 8'h14, 2'b00, 18'h1C3A5, 2'd0, "w");
      add(1'b0, 1'b0, 8'h14, 2'b00, '0, 2'd0, "R3 flow data lag");
      run(1);

      // R6: each chip select alone blocks a write and a read
      add(1'b1, 1'b0, 8'h10, 2'b00, 18'h0AAAA, 2'd1, "w");
      add(1'b1, 1'b0, 8'h10, 2'b00, 18'h15555, 2'd2, "w");
      add(1'b1, 1'b0, 8'h10, 2'b00, 18'h33333, 2'd3, "w");
      add(1'b0, 1'b0, 8'h10, 2'b00, '0, 2'd0, "R6 deselected writes ignored");
      add(1'b0, 1'b0, 8'h10, 2'b00, '0, 2'd2, "R6 deselected read undriven");
      run(1);

      burst_pass(1, 18'h01100, "R8 linear burst read", "R9 interleaved burst read");

      // R8: linear burst write from base 0x32, read back singly
      add(1'b1, 1'b0, 8'h32, 2'b00, 18'h2E000, 2'd0, "w");
      for (int i = 1; i < 4; i++) add(1'b1, 1'b1, 8'h00, 2'b00, 18'h2E000 + DW'(i), 2'd0, "w");
      for (int i = 0; i < 4; i++) add(1'b0, 1'b0, 8'h30 + AW'(i), 2'b00, '0, 2'd0, "R8 burst write");
      run(1);

      // R7: asynchronous output enable during a flow read
      @(negedge clk);
      adv = 1'b0; we_n = 1'b1; addr = 8'h14; ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
      @(negedge clk);
      idle_inputs();
      check("R7 drive before oe_n", dq_o, ref_mem[8'h14], dq_oe, 1'b1);
      oe_n = 1'b1;
      #0.5;
      check("R7 oe_n forces off", dq_o, '0, dq_oe, 1'b0);
      oe_n = 1'b0;
      #0.5;
      check("R7 oe_n released", dq_o, ref_mem[8'h14], dq_oe, 1'b1);

      // ---------------- pipelined ----------------
      do_reset(1'b1);
      table_pass(18'h15A5A, "R2 R4 R5 pipe vector");
      run(2);

      add(1'b1, 1'b0, 8'h15, 2'b00, 18'h0BEEF, 2'd0, "w");
      add(1'b0, 1'b0, 8'h15, 2'b00, '0, 2'd0, "R3 pipe data lag");
      add(1'b1, 1'b0, 8'h15, 2'b01, 18'h3F1F1, 2'd0, "w");
      add(1'b0, 1'b0, 8'h15, 2'b00, '0, 2'd0, "R4 R5 pipe forward lane merge");
      run(2);

      add(1'b1, 1'b0, 8'h16, 2'b00, 18'h12121, 2'd3, "w");
      add(1'b0, 1'b0, 8'h16, 2'b00, '0, 2'd1, "R6 pipe deselected read undriven");
      run(2);

      burst_pass(2, 18'h22200, "R2 R8 pipe linear burst", "R2 R9 pipe interleaved burst");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule